// File: doc/BRIEF.md
# Selectable Timestamp Counter and Capture Register

This block keeps a free-running upward timestamp count. It also holds a capture register that records the count when a chosen kind of trigger-side activity occurs. The count advances on one of two tick strobes, chosen by a select input: a 1 µs timebase tick or a beam-synchronous event strobe. A SYNC strobe returns the count to zero, which aligns timestamps across separate systems.

A second select picks which strobe copies the count into the readable timestamp register. The choices are a decoded event strobe, the first trigger pulse of a series, or the trigger counter's halt (terminal count). Capture can also be switched off. Each capture raises a one-cycle interrupt request. The captured value stays on the read port with a valid flag until a read acknowledge clears that flag. A capture that lands on an unread value still replaces it and sets an overrun flag. Event decoding and the bus protocol are handled elsewhere. All strobes are single-cycle and synchronous to `clk`.

Top module: `tsc_timestamp`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ts_o`, `ts_valid_o`, `overrun_o` and `irq_o` are 0, the count is 0, and first-pulse capture is armed.
- R2: With `cnt_src_i`=0 the count increments by one per cycle with `us_tick_i` high, and `bs_strobe_i` has no effect. With `cnt_src_i`=1 the roles of the two strobes are swapped.
- R3: A cycle with `sync_i` high makes the count 0 from the next cycle on, even if a selected tick is high in the same cycle.
- R4: The count wraps from all ones to zero with no flag or other side effect.
- R5: With `cap_sel_i`=0, a cycle with `cap_event_i` high copies the count as it stood in that cycle, before that cycle's tick, into `ts_o` on the next cycle.
- R6: With `cap_sel_i`=1, only the first `trig_pulse_i` after arming captures. Later pulses are ignored until a cycle with `rearm_i` high arms the block again.
- R7: With `cap_sel_i`=2, a cycle with `trig_halt_i` high captures the count.
- R8: Strobes that do not belong to the selected capture source cause no capture. With `cap_sel_i`=3, no strobe causes a capture. In these cases `ts_o`, `ts_valid_o` and `irq_o` are unaffected.
- R9: A capture always sets `ts_valid_o` and replaces `ts_o`, even if the previous value is unread. If `ts_valid_o` was high and `rd_ack_i` is low in the capture cycle, `overrun_o` is set.
- R10: A cycle with `rd_ack_i` high and no capture clears `ts_valid_o` and `overrun_o` and leaves `ts_o` unchanged. If a capture coincides with the acknowledge, the capture wins and `overrun_o` is cleared.
- R11: `irq_o` is high for exactly the one cycle in which a newly captured value first appears on `ts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick_i | input | 1 | 1 µs timebase tick strobe |
| bs_strobe_i | input | 1 | Beam-synchronous event strobe used as a tick |
| sync_i | input | 1 | SYNC strobe, clears the count |
| cnt_src_i | input | 1 | Tick source: 0 = µs tick, 1 = beam-sync strobe |
| cap_sel_i | input | 2 | Capture source: 0 event, 1 first pulse, 2 halt, 3 off |
| cap_event_i | input | 1 | Decoded event strobe chosen for capture |
| trig_pulse_i | input | 1 | Trigger pulse strobe |
| trig_halt_i | input | 1 | Trigger counter terminal-count strobe |
| rearm_i | input | 1 | Re-arms first-pulse capture |
| rd_ack_i | input | 1 | Read acknowledge for the captured value |
| ts_o | output | W (32) | Captured timestamp |
| ts_valid_o | output | 1 | Captured value not yet acknowledged |
| overrun_o | output | 1 | An unread value was overwritten |
| irq_o | output | 1 | One-cycle interrupt request per capture |

## Verification
On every cycle the assertions check the count arithmetic: increment on the selected tick, hold otherwise, and clear on SYNC. They also check that a capture loads exactly the prior cycle's count, that overwriting an unread value sets overrun, that an acknowledge clears the flags, and that the arm flag drops after a first-pulse capture. Only the bench scenarios can show that the right strobe is routed for each capture-select value, that ignored strobes leave the read port untouched, and that the count wraps through zero. They also cover the full sequence of arm, disarm and rearm across a series of pulses.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        CAP_EVENT = 2'd0,
        CAP_FIRST = 2'd1,
        CAP_HALT  = 2'd2,
        CAP_OFF   = 2'd3
    } cap_sel_e;

    typedef enum logic {
        SRC_MICRO = 1'b0,
        SRC_BEAM  = 1'b1
    } tick_src_e;

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         us_tick,
    input  logic         bs_strobe,
    input  logic         src,
    input  logic         sync,
    output logic [W-1:0] count
);
    import tsc_pkg::*;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       tick_sel;

    always_comb begin
        tick_sel = (tick_src_e'(src) == SRC_BEAM) ? bs_strobe : us_tick;
        st_d     = st_q;
        if (sync) begin
            st_d.cnt = '0;
        end else if (tick_sel) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/tsc_cap_select.sv
module tsc_cap_select (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ev,
    input  logic       pulse,
    input  logic       halt,
    input  logic       rearm,
    output logic       fire,
    output logic       armed
);
    import tsc_pkg::*;

    typedef struct packed {
        logic armed;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        fire = 1'b0;
        unique case (cap_sel_e'(sel))
            CAP_EVENT: fire = ev;
            CAP_FIRST: fire = pulse & st_q.armed;
            CAP_HALT:  fire = halt;
            CAP_OFF:   fire = 1'b0;
            default:   fire = 1'b0;
        endcase

        st_d = st_q;
        if (rearm) begin
            st_d.armed = 1'b1;
        end else if (fire && cap_sel_e'(sel) == CAP_FIRST) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{armed: 1'b1};
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/tsc_latch.sv
module tsc_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] count,
    input  logic         ack,
    output logic [W-1:0] ts,
    output logic         valid,
    output logic         ovr,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] ts;
        logic         valid;
        logic         ovr;
        logic         irq;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (fire) begin
            st_d.ts    = count;
            st_d.valid = 1'b1;
            st_d.ovr   = st_q.valid & ~ack;
            st_d.irq   = 1'b1;
        end else if (ack) begin
            st_d.valid = 1'b0;
            st_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts    = st_q.ts;
    assign valid = st_q.valid;
    assign ovr   = st_q.ovr;
    assign irq   = st_q.irq;

endmodule

// File: rtl/tsc_timestamp.sv
module tsc_timestamp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         us_tick_i,
    input  logic         bs_strobe_i,
    input  logic         sync_i,
    input  logic         cnt_src_i,
    input  logic [1:0]   cap_sel_i,
    input  logic         cap_event_i,
    input  logic         trig_pulse_i,
    input  logic         trig_halt_i,
    input  logic         rearm_i,
    input  logic         rd_ack_i,
    output logic [W-1:0] ts_o,
    output logic         ts_valid_o,
    output logic         overrun_o,
    output logic         irq_o
);
    logic [W-1:0] cnt_w;
    logic         fire_w;
    logic         armed_w;

    tsc_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick_i),
        .bs_strobe (bs_strobe_i),
        .src       (cnt_src_i),
        .sync      (sync_i),
        .count     (cnt_w)
    );

    tsc_cap_select u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cap_sel_i),
        .ev    (cap_event_i),
        .pulse (trig_pulse_i),
        .halt  (trig_halt_i),
        .rearm (rearm_i),
        .fire  (fire_w),
        .armed (armed_w)
    );

    tsc_latch #(.W(W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire_w),
        .count (cnt_w),
        .ack   (rd_ack_i),
        .ts    (ts_o),
        .valid (ts_valid_o),
        .ovr   (overrun_o),
        .irq   (irq_o)
    );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         us_tick_i,
    input logic         bs_strobe_i,
    input logic         sync_i,
    input logic         cnt_src_i,
    input logic [1:0]   cap_sel_i,
    input logic         trig_pulse_i,
    input logic         rearm_i,
    input logic         rd_ack_i,
    input logic [W-1:0] ts_o,
    input logic         ts_valid_o,
    input logic         overrun_o,
    input logic         irq_o,
    input logic [W-1:0] cnt_w,
    input logic         fire_w,
    input logic         armed_w
);
    logic sel_tick;
    assign sel_tick = cnt_src_i ? bs_strobe_i : us_tick_i;

    // R2
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && sel_tick) |=> cnt_w == W'($past(cnt_w) + 1'b1));

    // R2
    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !sel_tick) |=> $stable(cnt_w));

    // R3
    p_sync_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> cnt_w == '0);

    // R5
    p_capture_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w |=> (ts_o == $past(cnt_w)) && ts_valid_o && irq_o);

    // R6
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sel_i == 2'd1 && trig_pulse_i && armed_w && !rearm_i) |=> !armed_w);

    // R9
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w && ts_valid_o && !rd_ack_i) |=> overrun_o);

    // R10
    p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_i && !fire_w) |=> (!ts_valid_o && !overrun_o && $stable(ts_o)));

    // R11
    p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_w) |=> !irq_o);

    // R9
    p_ovr_implies_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ts_valid_o);

endmodule

bind tsc_timestamp tsc_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick_i    (us_tick_i),
    .bs_strobe_i  (bs_strobe_i),
    .sync_i       (sync_i),
    .cnt_src_i    (cnt_src_i),
    .cap_sel_i    (cap_sel_i),
    .trig_pulse_i (trig_pulse_i),
    .rearm_i      (rearm_i),
    .rd_ack_i     (rd_ack_i),
    .ts_o         (ts_o),
    .ts_valid_o   (ts_valid_o),
    .overrun_o    (overrun_o),
    .irq_o        (irq_o),
    .cnt_w        (cnt_w),
    .fire_w       (fire_w),
    .armed_w      (armed_w)
);

// File: tb/tsc_timestamp_test.sv
module tsc_timestamp_test;

    localparam int W = 8;
    localparam int NV = 21;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         us_tick_i, bs_strobe_i, sync_i, cnt_src_i;
    logic [1:0]   cap_sel_i;
    logic         cap_event_i, trig_pulse_i, trig_halt_i, rearm_i, rd_ack_i;
    logic [W-1:0] ts_o;
    logic         ts_valid_o, overrun_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tsc_timestamp #(.W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick_i    (us_tick_i),
        .bs_strobe_i  (bs_strobe_i),
        .sync_i       (sync_i),
        .cnt_src_i    (cnt_src_i),
        .cap_sel_i    (cap_sel_i),
        .cap_event_i  (cap_event_i),
        .trig_pulse_i (trig_pulse_i),
        .trig_halt_i  (trig_halt_i),
        .rearm_i      (rearm_i),
        .rd_ack_i     (rd_ack_i),
        .ts_o         (ts_o),
        .ts_valid_o   (ts_valid_o),
        .overrun_o    (overrun_o),
        .irq_o        (irq_o)
    );

    // stimulus bits: [10]us_tick [9]bs_strobe [8]sync [7]cnt_src [6:5]cap_sel
    //                [4]cap_event [3]trig_pulse [2]trig_halt [1]rearm [0]rd_ack
    // expected: ts, valid, overrun, irq
    localparam logic [21:0] VEC [0:NV-1] = '{
        {11'b1_0_0_0_11_0_0_0_0_0, 8'd0, 3'b000}, // R2 us tick counts
        {11'b1_0_0_0_11_0_0_0_0_0, 8'd0, 3'b000}, // R2
        {11'b0_1_0_0_11_0_0_0_0_0, 8'd0, 3'b000}, // R2 beam strobe ignored
        {11'b0_0_0_0_00_1_0_0_0_0, 8'd2, 3'b101}, // R5 event capture, R11
        {11'b0_0_0_0_11_0_0_0_0_1, 8'd2, 3'b000}, // R10 ack
        {11'b0_1_0_1_11_0_0_0_0_0, 8'd2, 3'b000}, // R2 beam counts
        {11'b1_0_0_1_11_0_0_0_0_0, 8'd2, 3'b000}, // R2 us tick ignored
        {11'b0_1_0_1_00_1_0_0_0_0, 8'd3, 3'b101}, // R5 pre-tick value
        {11'b0_0_0_1_00_1_0_0_0_0, 8'd4, 3'b111}, // R9 overwrite + overrun
        {11'b0_0_0_1_11_0_0_0_0_1, 8'd4, 3'b000}, // R10 clears both
        {11'b0_1_0_1_01_0_1_0_0_0, 8'd4, 3'b101}, // R6 first pulse
        {11'b0_1_0_1_01_0_1_0_0_1, 8'd4, 3'b000}, // R6 second pulse ignored
        {11'b0_0_0_1_01_0_0_0_1_0, 8'd4, 3'b000}, // R6 rearm
        {11'b0_0_0_1_01_0_1_0_0_0, 8'd6, 3'b101}, // R6 capture after rearm
        {11'b0_1_0_1_11_0_0_0_0_1, 8'd6, 3'b000}, // R10
        {11'b0_0_0_1_10_0_0_1_0_0, 8'd7, 3'b101}, // R7 halt capture
        {11'b0_0_0_1_10_1_1_0_0_1, 8'd7, 3'b000}, // R8 other strobes ignored
        {11'b1_0_1_0_11_0_0_0_0_0, 8'd7, 3'b000}, // R3 sync beats tick
        {11'b0_0_0_0_00_1_0_0_0_0, 8'd0, 3'b101}, // R3 count is zero
        {11'b1_0_0_0_00_1_0_0_0_1, 8'd0, 3'b101}, // R10 capture wins over ack
        {11'b0_0_0_0_11_1_1_1_0_0, 8'd0, 3'b100}  // R8 capture off
    };

    task automatic drive(input logic [10:0] s);
        {us_tick_i, bs_strobe_i, sync_i, cnt_src_i, cap_sel_i,
         cap_event_i, trig_pulse_i, trig_halt_i, rearm_i, rd_ack_i} = s;
    endtask

    task automatic check(input string req, input logic [W-1:0] ets,
                         input logic ev, input logic eo, input logic ei);
        n_checks++;
        if (ts_o !== ets || ts_valid_o !== ev || overrun_o !== eo || irq_o !== ei) begin
            n_fail++;
            $display("FAIL %s: got ts=%0d v=%0b o=%0b irq=%0b, expected ts=%0d v=%0b o=%0b irq=%0b",
                     req, ts_o, ts_valid_o, overrun_o, irq_o, ets, ev, eo, ei);
        end
    endtask

    task automatic check_ts(input string req, input logic [W-1:0] ets);
        n_checks++;
        if (ts_o !== ets) begin
            n_fail++;
            $display("FAIL %s: got ts=%0d, expected ts=%0d", req, ts_o, ets);
        end
    endtask

    task automatic step(input logic [10:0] s);
        drive(s);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        drive(11'b0_0_0_0_11_0_0_0_0_0);
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", '0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21:11]);
            check($sformatf("vector %0d", i), VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset mid-run clears everything, first-pulse re-armed
        rst_n = 1'b0;
        step(11'b0_0_0_0_11_0_0_0_0_0);
        check("R1 mid-run reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(11'b0_0_0_0_01_0_1_0_0_0);
        check("R1 armed after reset", '0, 1'b1, 1'b0, 1'b1);
        step(11'b0_0_0_0_11_0_0_0_0_1);

        // R4: wrap through all ones
        for (int k = 0; k < 255; k++) step(11'b1_0_0_0_11_0_0_0_0_0);
        step(11'b0_0_0_0_00_1_0_0_0_0);
        check("R4 all ones", 8'd255, 1'b1, 1'b0, 1'b1);
        step(11'b1_0_0_0_11_0_0_0_0_1);
        step(11'b0_0_0_0_00_1_0_0_0_0);
        check("R4 wrapped to zero", 8'd0, 1'b1, 1'b0, 1'b1);
        step(11'b0_0_0_0_11_0_0_0_0_0);
        check("R11 irq single cycle", 8'd0, 1'b1, 1'b0, 1'b0);

        // R8: event strobe while halt selected, after ack
        step(11'b0_0_0_0_11_0_0_0_0_1);
        step(11'b1_0_0_0_10_1_0_0_0_0);
        check_ts("R8 event ignored under halt select", 8'd0);
        step(11'b0_0_0_0_10_0_0_1_0_0);
        check("R7 halt after tick", 8'd1, 1'b1, 1'b0, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule